// File: doc/BRIEF.md
# CVSD Speech Encoder

A digital continuously variable slope delta encoder. Each clock it takes one signed audio sample, already band-limited and presented at the bit rate, and produces one baseband bit. The bit records whether the sample lies above the encoder's own running estimate of the waveform. The three most recent bits are kept in a short history. A run of three identical bits means the estimate cannot keep up with the input. A run detector flags that condition, and the flag drives an exponential syllabic filter. The filter's output sets the size of the step that the encoder adds to, or subtracts from, a leaky, saturating reconstruction integrator. The integrator's value is the estimate used in the next comparison.

The run detector is a two-state machine. `MODE_DISCHARGE` is the reset state and the idle state. `MODE_CHARGE` is entered for one clock after the history is full and holds three equal bits. The machine goes from either state to `MODE_CHARGE` on that condition, and from either state to `MODE_DISCHARGE` in every other case. In `MODE_CHARGE` the syllabic state climbs toward full scale. In `MODE_DISCHARGE` it decays toward zero. The per-clock coefficient is chosen by `rate_sel` so that the time constant stays near 5 ms at both 16 kbit/s and 32 kbit/s.

The block exposes the step size and the reconstruction estimate next to the bit. A link partner or a test rig can then follow the decoder-side waveform without rebuilding it.

Top module: `cvsd_encoder`

## Requirements
- R1: A synchronous reset clears the history, the fill count, the run state, the syllabic state and the integrator. After reset `bit_out`=0, `overload`=0, `step_mag` equals the floor (MAX_STEP/16 = 64 by default) and `recon`=0.
- R2: On each clock the encoder shifts a new bit into the history. The bit is 1 when the signed `sample_in` is strictly greater than `recon` and 0 otherwise. `bit_out` shows this newest bit from the clock edge that captured the sample.
- R3: `overload` is 1 for the clock that follows a shift which leaves three equal bits in the history. This happens only after at least three shifts since reset. In every other case `overload` is 0.
- R4: The syllabic state s updates each clock from the current run state. In `MODE_CHARGE` it does s += (SMAX − s) >> k. In `MODE_DISCHARGE` it does s −= s >> k. SMAX = MAX_STEP·2^FRAC.
- R5: k = K_SLOW (6) when `rate_sel`=0 (16 kbit/s) and k = K_FAST (7) when `rate_sel`=1 (32 kbit/s).
- R6: `step_mag` = max(s >> FRAC, MAX_STEP/16). It never exceeds MAX_STEP.
- R7: On each clock the next `recon` = `recon` − (`recon` >>> LEAK) ± `step_mag`. The step is added when the newly captured bit is 1 and subtracted when it is 0. Both `recon` and `step_mag` are the values before the edge.
- R8: The integrator clamps to [−2^(W−1), 2^(W−1)−1] and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | 0 selects the 16 kbit/s coefficient, 1 selects the 32 kbit/s coefficient |
| sample_in | input | W | Signed linear input sample |
| bit_out | output | 1 | Baseband bit (newest history bit) |
| overload | output | 1 | Run-of-three flag (run state is `MODE_CHARGE`) |
| step_mag | output | STEP_W | Current step magnitude |
| recon | output | W | Signed reconstruction estimate |

## Verification
A wrong history bit shows up on `bit_out` at the same edge and reaches `recon` at that edge too, because it sets the step sign. A corrupted run detector shows up on `overload` one clock after the faulty history. It then moves `step_mag` on the following clock, so a lag or off-by-one in the fill gating is caught within two cycles of reset. An error in the syllabic coefficient builds up slowly: it shows as a `step_mag` mismatch after a few tens of charging cycles, and sooner at 16 kbit/s than at 32 kbit/s. Errors in leak or saturation appear on `recon` at the first edge where they matter, which for the clamp is the edge where the estimate reaches full scale.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

    // Run detector state: drives the syllabic filter direction.
    typedef enum logic {
        MODE_DISCHARGE = 1'b0,
        MODE_CHARGE    = 1'b1
    } syl_mode_e;

endpackage

// File: rtl/cvsd_history.sv
module cvsd_history
    import cvsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    output logic [2:0] hist_o,
    output syl_mode_e  mode_o
);

    logic [2:0] hist_q;
    logic [1:0] fill_q;
    syl_mode_e  mode_q, mode_n;
    logic       run_seen;

    // History register and fill counter (saturates once three bits are held).
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 3'b000;
            fill_q <= 2'd0;
        end else begin
            hist_q <= {hist_q[1:0], bit_in};
            if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
        end
    end

    assign run_seen = (fill_q == 2'd3) && ((hist_q == 3'b000) || (hist_q == 3'b111));

    // State register.
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_DISCHARGE;
        else     mode_q <= mode_n;
    end

    // Next state.
    always_comb begin
        mode_n = MODE_DISCHARGE;
        unique case (mode_q)
            MODE_DISCHARGE: mode_n = run_seen ? MODE_CHARGE : MODE_DISCHARGE;
            MODE_CHARGE:    mode_n = run_seen ? MODE_CHARGE : MODE_DISCHARGE;
            default:        mode_n = MODE_DISCHARGE;
        endcase
    end

    assign hist_o = hist_q;
    assign mode_o = mode_q;

    // R3: the charge state implies the newest bit matched on the three prior edges
    a_r3_overload_after_run: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_CHARGE) |->
            (($past(hist_q[0], 1) == $past(hist_q[0], 2)) &&
             ($past(hist_q[0], 2) == $past(hist_q[0], 3))));

    // R3: no run flag until three bits were shifted in since reset
    a_r3_needs_full_history: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_CHARGE) |-> $past(fill_q) == 2'd3);

endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic
    import cvsd_pkg::*;
#(
    parameter int MAX_STEP = 1024,
    parameter int FRAC     = 8,
    parameter int K_SLOW   = 6,
    parameter int K_FAST   = 7,
    localparam int STEP_W  = $clog2(MAX_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    input  syl_mode_e         mode_i,
    output logic [STEP_W-1:0] step_o
);

    localparam int SW = $clog2(MAX_STEP) + FRAC + 1;
    localparam logic [SW-1:0]     SMAX  = SW'(MAX_STEP * (2 ** FRAC));
    localparam logic [STEP_W-1:0] FLOOR = STEP_W'(MAX_STEP / 16);

    logic [SW-1:0] syl_q, syl_n, gap, inc, dec, raw;
    int unsigned   kshift;

    assign kshift = rate_sel ? K_FAST : K_SLOW;
    assign gap    = SMAX - syl_q;
    assign inc    = gap >> kshift;
    assign dec    = syl_q >> kshift;

    always_comb begin
        syl_n = syl_q;
        unique case (mode_i)
            MODE_CHARGE:    syl_n = syl_q + inc;
            MODE_DISCHARGE: syl_n = syl_q - dec;
            default:        syl_n = syl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) syl_q <= '0;
        else     syl_q <= syl_n;
    end

    assign raw    = syl_q >> FRAC;
    assign step_o = (raw < SW'(FLOOR)) ? FLOOR : raw[STEP_W-1:0];

    // R4: charging never lowers the syllabic state
    a_r4_charge_no_fall: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_CHARGE) |=> syl_q >= $past(syl_q));

    // R4: discharging never raises the syllabic state
    a_r4_discharge_no_rise: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_DISCHARGE) |=> syl_q <= $past(syl_q));

    // R6: the state never passes full scale
    a_r6_within_full_scale: assert property (@(posedge clk) disable iff (rst)
        syl_q <= SMAX);

endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
    parameter int W      = 16,
    parameter int STEP_W = 11,
    parameter int LEAK   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                up_i,
    input  logic [STEP_W-1:0]   step_i,
    output logic signed [W-1:0] recon_o
);

    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] HI = XW'((2 ** (W - 1)) - 1);
    localparam logic signed [XW-1:0] LO = -HI - XW'(1);

    logic signed [W-1:0]  recon_q, recon_n;
    logic signed [XW-1:0] r_x, step_x, sum_x;

    assign r_x    = XW'(recon_q);
    assign step_x = $signed({{(XW - STEP_W){1'b0}}, step_i});
    assign sum_x  = r_x - (r_x >>> LEAK) + (up_i ? step_x : -step_x);

    always_comb begin
        if (sum_x > HI)      recon_n = HI[W-1:0];
        else if (sum_x < LO) recon_n = LO[W-1:0];
        else                 recon_n = sum_x[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) recon_q <= '0;
        else     recon_q <= recon_n;
    end

    assign recon_o = recon_q;

    // R7: from a negative estimate an up-step always raises it
    a_r7_up_from_negative: assert property (@(posedge clk) disable iff (rst)
        (up_i && recon_q < 0) |=> recon_q > $past(recon_q));

    // R7: from a positive estimate a down-step always lowers it
    a_r7_down_from_positive: assert property (@(posedge clk) disable iff (rst)
        (!up_i && recon_q > 0) |=> recon_q < $past(recon_q));

endmodule

// File: rtl/cvsd_encoder.sv
module cvsd_encoder
    import cvsd_pkg::*;
#(
    parameter int W        = 16,
    parameter int MAX_STEP = 1024,
    parameter int FRAC     = 8,
    parameter int K_SLOW   = 6,
    parameter int K_FAST   = 7,
    parameter int LEAK     = 8,
    localparam int STEP_W  = $clog2(MAX_STEP + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rate_sel,
    input  logic signed [W-1:0] sample_in,
    output logic                bit_out,
    output logic                overload,
    output logic [STEP_W-1:0]   step_mag,
    output logic signed [W-1:0] recon
);

    logic        cmp_bit;
    logic [2:0]  hist;
    syl_mode_e   mode;

    assign cmp_bit = (sample_in > recon);

    cvsd_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .bit_in (cmp_bit),
        .hist_o (hist),
        .mode_o (mode)
    );

    cvsd_syllabic #(
        .MAX_STEP (MAX_STEP),
        .FRAC     (FRAC),
        .K_SLOW   (K_SLOW),
        .K_FAST   (K_FAST)
    ) u_syl (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .mode_i   (mode),
        .step_o   (step_mag)
    );

    cvsd_integrator #(
        .W      (W),
        .STEP_W (STEP_W),
        .LEAK   (LEAK)
    ) u_int (
        .clk     (clk),
        .rst     (rst),
        .up_i    (cmp_bit),
        .step_i  (step_mag),
        .recon_o (recon)
    );

    assign bit_out  = hist[0];
    assign overload = (mode == MODE_CHARGE);

    // R2: the output bit is the comparison made at the previous edge
    a_r2_bit_is_comparison: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> bit_out == $past(sample_in > recon));

endmodule

// File: tb/tb_cvsd_encoder.sv
module tb_cvsd_encoder;

    localparam int W        = 16;
    localparam int MAX_STEP = 1024;
    localparam int FRAC     = 8;
    localparam int LEAK     = 8;
    localparam int SMAX     = MAX_STEP * (2 ** FRAC);
    localparam int FLOOR    = MAX_STEP / 16;
    localparam int HI       = (2 ** (W - 1)) - 1;
    localparam int LO       = -(2 ** (W - 1));

    typedef struct {
        logic b;
        logic o;
        int   st;
        int   rc;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                rate_sel = 1'b0;
    logic signed [W-1:0] sample_in = '0;
    logic                bit_out, overload;
    logic [10:0]         step_mag;
    logic signed [W-1:0] recon;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // reference state
    int m_hist = 0, m_fill = 0, m_ovl = 0, m_syl = 0, m_int = 0;
    int hit_hi = 0;

    always #2 clk = ~clk;

    cvsd_encoder dut (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .sample_in (sample_in),
        .bit_out   (bit_out),
        .overload  (overload),
        .step_mag  (step_mag),
        .recon     (recon)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int step_of(input int s);
        int r;
        r = s >> FRAC;
        return (r < FLOOR) ? FLOOR : r;
    endfunction

    // Driver: apply one sample and push the expected post-edge outputs.
    task automatic drive(input int s, input bit rs, input bit rate);
        exp_t e;
        int cmp, hist_n, fill_n, ovl_n, syl_n, int_n, k, st;
        @(negedge clk);
        sample_in = W'(s);
        rst       = rs;
        rate_sel  = rate;
        if (rs) begin
            m_hist = 0; m_fill = 0; m_ovl = 0; m_syl = 0; m_int = 0;
        end else begin
            cmp    = (s > m_int) ? 1 : 0;
            hist_n = ((m_hist << 1) | cmp) & 7;
            fill_n = (m_fill < 3) ? m_fill + 1 : 3;
            ovl_n  = (m_fill == 3 && (m_hist == 0 || m_hist == 7)) ? 1 : 0;
            k      = rate ? 7 : 6;
            syl_n  = m_ovl ? m_syl + ((SMAX - m_syl) >> k) : m_syl - (m_syl >> k);
            st     = step_of(m_syl);
            int_n  = m_int - (m_int >>> LEAK) + (cmp ? st : -st);
            if (int_n > HI) int_n = HI;
            if (int_n < LO) int_n = LO;
            m_hist = hist_n; m_fill = fill_n; m_ovl = ovl_n; m_syl = syl_n; m_int = int_n;
        end
        e.b  = m_hist[0];
        e.o  = m_ovl[0];
        e.st = step_of(m_syl);
        e.rc = m_int;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(bit_out == e.b, "R2 bit_out", int'(bit_out), int'(e.b));
                chk(overload == e.o, "R3 overload", int'(overload), int'(e.o));
                chk(int'(step_mag) == e.st, "R4/R5/R6 step_mag", int'(step_mag), e.st);
                chk(int'(recon) == e.rc, "R7/R8 recon", int'(recon), e.rc);
                if (int'(recon) == HI) hit_hi = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s16, s32;
        // R1: reset state
        drive(0, 1, 0);
        drive(0, 1, 0);
        @(posedge clk); #1;
        chk(bit_out == 1'b0 && overload == 1'b0, "R1 reset bit/overload",
            int'({bit_out, overload}), 0);
        chk(int'(step_mag) == FLOOR, "R1 reset step floor", int'(step_mag), FLOOR);
        chk(int'(recon) == 0, "R1 reset recon", int'(recon), 0);

        // R3: zero input -> idle alternation, no early flag from the cleared history
        for (int i = 0; i < 40; i++) drive(0, 0, 0);

        // R5: rate comparison after a charging burst
        drive(0, 1, 0);
        for (int i = 0; i < 30; i++) drive(HI, 0, 0);
        @(posedge clk); #1;
        s16 = int'(step_mag);
        drive(0, 1, 1);
        for (int i = 0; i < 30; i++) drive(HI, 0, 1);
        @(posedge clk); #1;
        s32 = int'(step_mag);
        chk(s16 > s32, "R5 16k coefficient charges faster", s16, s32);

        // R8: drive to positive full scale
        drive(0, 1, 0);
        for (int i = 0; i < 600; i++) drive(HI, 0, 0);
        chk(hit_hi == 1, "R8 clamp reached at positive full scale", hit_hi, 1);

        // R8/R7: swing to negative full scale
        for (int i = 0; i < 600; i++) drive(LO, 0, 0);

        // R2/R4/R6: triangle wave at both rates
        for (int i = 0; i < 512; i++) begin
            int ph, v;
            ph = i % 64;
            v  = (ph < 32) ? (ph * 500 - 8000) : (8000 - (ph - 32) * 500);
            drive(v, 0, (i >= 256));
        end

        // R1: mid-run reset then resume
        drive(0, 1, 0);
        @(posedge clk); #1;
        chk(int'(recon) == 0 && overload == 1'b0, "R1 mid-run reset", int'(recon), 0);
        for (int i = 0; i < 20; i++) drive(-3000, 0, 0);

        repeat (3) @(posedge clk);
        #1;
        chk(q.size() == 0, "scoreboard drained", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule